// File: doc/BRIEF.md
# Seconds Clock with Alarm, Watchdog and Ordered Commit Tracking

This block is a memory-mapped real-time clock. It holds a seconds counter that advances on a 1 Hz tick, a seconds alarm that raises an interrupt, and a watchdog countdown that advances on a millisecond tick and requests a reset when it expires. Software reaches it over a simple register bus. The bus writes in the same cycle and reads combinationally. The control register and the two persistent registers each have three write addresses: one replaces the register, one ORs bits in and one clears bits.

The time-keeping registers are SECONDS, ALARM and the two persistent registers. A write to one of them does not take effect at once. The value is held on the bus side and the register is marked stale in the status register. An update strobe then moves the held values into the always-on domain, one register per strobe. Reads of these registers return the committed value. Software polls the stale field to learn when a write has landed. The oscillator and power bits in the persistent register are only stored. The register bus has no back-pressure: every write is accepted in the cycle it is presented, and no data path uses a valid/ready handshake.

Top module: `rtc_keeper`

## Requirements
- R1: After reset, CTRL, SECONDS, ALARM, WATCHDOG and both persistent registers read 0, and the stale field is 0.
- R2: CTRL has three write addresses. A write to 0x00 replaces bits 0 (alarm interrupt enable), 1 (millisecond interrupt enable) and 4 (watchdog enable). A write to 0x04 ORs the data into those bits. A write to 0x08 clears the bits that are set in the data. All other CTRL bits except bit 2 read 0.
- R3: A write to PERSISTENT0 (0x60, 0x64 or 0x68) sets stale bit 0, and a write to PERSISTENT1 (0x70, 0x74 or 0x78) sets stale bit 1. A write to ALARM (0x40) sets stale bit 6 and a write to SECONDS (0x30) sets stale bit 7. The stale field is STAT bits 23:16. Until the register is committed, its address keeps reading the old value.
- R4: Each cycle with the update strobe high commits the single stale register with the lowest bit number, and clears that stale bit.
- R5: A write to PERSISTENT1 that leaves bit 31 set marks all eight stale bits. The commits that follow carry the current register values, so no register changes.
- R6: Each 1 Hz tick adds one to the committed seconds value, unless a SECONDS commit happens in the same cycle. In that case the commit wins.
- R7: When a tick makes the seconds value equal to ALARM and PERSISTENT0 bit 2 (alarm enable) is set, CTRL bit 2 (alarm flag) is set. The flag is cleared only by a write to 0x08 with data bit 2 set. Writes to 0x00 or 0x04 leave it unchanged. alarm_irq is high while CTRL bits 2 and 0 are both set.
- R8: When the alarm fires and PERSISTENT0 bit 1 (wake enable) is also set, PERSISTENT0 bit 7 (wake flag) is set.
- R9: A write to WATCHDOG (0x50) loads the count. The count falls by one on each millisecond tick only while CTRL bit 4 is set, and it holds at 0.
- R10: wdog_rst_req is high for exactly one cycle, in the cycle after a tick takes the count from 1 to 0. Writing 0 or ticking at 0 gives no pulse.
- R11: STAT (0x10) reads bit 31 as 1, bit 28 as strap_xtal32000 and bit 27 as strap_xtal32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sec_tick | input | 1 | One-cycle 1 Hz tick |
| ms_tick | input | 1 | One-cycle millisecond tick |
| upd_strobe | input | 1 | Commit slot toward the always-on domain |
| strap_xtal32000 | input | 1 | 32000 Hz crystal present strap |
| strap_xtal32768 | input | 1 | 32768 Hz crystal present strap |
| alarm_irq | output | 1 | Alarm interrupt |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest case to reach is a full forced queue. It commits all eight slots, including the four unbacked persistent slots, while the committed registers hold values the bus side never wrote directly: a seconds value moved on by ticks and a wake flag set by the alarm. The bench builds that state first. It commits SECONDS, ALARM and PERSISTENT0 one strobe at a time and ticks the counter into the alarm. Only then does it set the force bit. It then steps the strobe eight times, checks that one stale bit clears each time in order, and checks that no register changed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_SLOTS = 8;

  // address regions (upper nibble of the byte address)
  localparam logic [3:0] RGN_CTRL = 4'h0;
  localparam logic [3:0] RGN_STAT = 4'h1;
  localparam logic [3:0] RGN_SEC  = 4'h3;
  localparam logic [3:0] RGN_ALM  = 4'h4;
  localparam logic [3:0] RGN_WDG  = 4'h5;
  localparam logic [3:0] RGN_P0   = 4'h6;
  localparam logic [3:0] RGN_P1   = 4'h7;

  // commit slots, lowest number commits first
  localparam int SLOT_P0  = 0;
  localparam int SLOT_P1  = 1;
  localparam int SLOT_ALM = 6;
  localparam int SLOT_SEC = 7;

  localparam int CTRL_ALM_IE   = 0;
  localparam int CTRL_ALM_FLAG = 2;
  localparam int CTRL_WD_EN    = 4;
  localparam logic [DATA_W-1:0] CTRL_RW_MASK = 32'h0000_0013;

  localparam int P0_WAKE_EN   = 1;
  localparam int P0_ALM_EN    = 2;
  localparam int P0_WAKE_FLAG = 7;
  localparam int P1_FORCE     = 31;

  typedef enum logic [1:0] {OP_WRITE, OP_SET, OP_CLR, OP_NONE} wr_op_e;

  function automatic logic [DATA_W-1:0] apply_op(logic [DATA_W-1:0] old,
                                                logic [DATA_W-1:0] d,
                                                wr_op_e op);
    case (op)
      OP_WRITE: return d;
      OP_SET:   return old | d;
      OP_CLR:   return old & ~d;
      default:  return old;
    endcase
  endfunction
endpackage

// File: rtl/rtc_xfer_queue.sv
module rtc_xfer_queue #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     mark,
  input  logic             strobe,
  output logic [N-1:0]     stale_q,
  output logic             commit_valid,
  output logic [IDX_W-1:0] commit_idx
);
  logic found;
  logic [N-1:0] done_mask;

  // lowest-numbered pending slot wins the strobe
  always_comb begin
    found      = 1'b0;
    commit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && stale_q[i]) begin
        found      = 1'b1;
        commit_idx = IDX_W'(i);
      end
    end
    commit_valid = strobe && found;
    done_mask    = '0;
    if (commit_valid) done_mask[commit_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stale_q <= '0;
    else        stale_q <= (stale_q & ~done_mask) | mark;
  end
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic         tick,
  output logic [W-1:0] count_q,
  output logic         rst_req_q
);
  logic last_step;
  assign last_step = !load && tick && en && (count_q == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= last_step;
      if (load)                                count_q <= load_val;
      else if (tick && en && count_q != '0)    count_q <= count_q - W'(1);
    end
  end
endmodule

// File: rtl/rtc_keeper.sv
module rtc_keeper
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sec_tick,
  input  logic              ms_tick,
  input  logic              upd_strobe,
  input  logic              strap_xtal32000,
  input  logic              strap_xtal32768,
  output logic              alarm_irq,
  output logic              wdog_rst_req
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  wr_op_e      op;
  logic [3:0]  region;
  logic        wr_ctrl, wr_p0, wr_p1, wr_sec, wr_alm, wr_wdg;
  logic [DATA_W-1:0] p0_wval, p1_wval;
  logic        force_all;
  logic [NUM_SLOTS-1:0] mark, stale_q;
  logic        commit_valid;
  logic [IDX_W-1:0] commit_idx;
  logic        commit_p0, commit_p1, commit_alm, sec_commit;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] hold_p0_q, hold_p1_q, hold_alm_q, hold_sec_q;
  logic [DATA_W-1:0] live_p0_q, live_p1_q, live_alm_q, live_sec_q;
  logic [DATA_W-1:0] sec_plus, wd_count, stat_val;
  logic        alarm_hit;

  // ---------------- bus decode ----------------
  assign region = bus_addr[ADDR_W-1:4];
  always_comb begin
    case (bus_addr[3:0])
      4'h0:    op = OP_WRITE;
      4'h4:    op = OP_SET;
      4'h8:    op = OP_CLR;
      default: op = OP_NONE;
    endcase
  end

  assign wr_ctrl = bus_wr && region == RGN_CTRL && op != OP_NONE;
  assign wr_p0   = bus_wr && region == RGN_P0   && op != OP_NONE;
  assign wr_p1   = bus_wr && region == RGN_P1   && op != OP_NONE;
  assign wr_sec  = bus_wr && region == RGN_SEC  && op == OP_WRITE;
  assign wr_alm  = bus_wr && region == RGN_ALM  && op == OP_WRITE;
  assign wr_wdg  = bus_wr && region == RGN_WDG  && op == OP_WRITE;

  assign p0_wval   = apply_op(hold_p0_q, bus_wdata, op);
  assign p1_wval   = apply_op(hold_p1_q, bus_wdata, op);
  assign force_all = wr_p1 && p1_wval[P1_FORCE];

  always_comb begin
    mark = '0;
    if (force_all) mark = '1;
    else begin
      mark[SLOT_P0]  = wr_p0;
      mark[SLOT_P1]  = wr_p1;
      mark[SLOT_ALM] = wr_alm;
      mark[SLOT_SEC] = wr_sec;
    end
  end

  // ---------------- ordered commit queue ----------------
  rtc_xfer_queue #(.N(NUM_SLOTS)) i_queue (
    .clk(clk), .rst_n(rst_n), .mark(mark), .strobe(upd_strobe),
    .stale_q(stale_q), .commit_valid(commit_valid), .commit_idx(commit_idx)
  );

  assign commit_p0  = commit_valid && commit_idx == IDX_W'(SLOT_P0);
  assign commit_p1  = commit_valid && commit_idx == IDX_W'(SLOT_P1);
  assign commit_alm = commit_valid && commit_idx == IDX_W'(SLOT_ALM);
  assign sec_commit = commit_valid && commit_idx == IDX_W'(SLOT_SEC);

  // bus-side holding values follow the committed value while not pending
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_p0_q  <= '0;
      hold_p1_q  <= '0;
      hold_alm_q <= '0;
      hold_sec_q <= '0;
    end else begin
      if (wr_p0)                        hold_p0_q  <= p0_wval;
      else if (!stale_q[SLOT_P0])       hold_p0_q  <= live_p0_q;
      if (wr_p1)                        hold_p1_q  <= p1_wval;
      else if (!stale_q[SLOT_P1])       hold_p1_q  <= live_p1_q;
      if (wr_alm)                       hold_alm_q <= bus_wdata;
      else if (!stale_q[SLOT_ALM])      hold_alm_q <= live_alm_q;
      if (wr_sec)                       hold_sec_q <= bus_wdata;
      else if (!stale_q[SLOT_SEC])      hold_sec_q <= live_sec_q;
    end
  end

  // ---------------- always-on domain ----------------
  assign sec_plus  = live_sec_q + DATA_W'(1);
  assign alarm_hit = sec_tick && !sec_commit && sec_plus == live_alm_q
                     && live_p0_q[P0_ALM_EN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_p0_q  <= '0;
      live_p1_q  <= '0;
      live_alm_q <= '0;
      live_sec_q <= '0;
    end else begin
      if (sec_commit)    live_sec_q <= hold_sec_q;
      else if (sec_tick) live_sec_q <= sec_plus;
      if (commit_alm)    live_alm_q <= hold_alm_q;
      if (commit_p1)     live_p1_q  <= hold_p1_q;
      if (commit_p0)     live_p0_q  <= hold_p0_q;
      else if (alarm_hit && live_p0_q[P0_WAKE_EN])
        live_p0_q[P0_WAKE_FLAG] <= 1'b1;
    end
  end

  // ---------------- control register ----------------
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = (apply_op(ctrl_q, bus_wdata, op) & CTRL_RW_MASK)
             | (ctrl_q & ~CTRL_RW_MASK);
      if (op == OP_CLR && bus_wdata[CTRL_ALM_FLAG]) ctrl_d[CTRL_ALM_FLAG] = 1'b0;
    end
    if (alarm_hit) ctrl_d[CTRL_ALM_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign alarm_irq = ctrl_q[CTRL_ALM_FLAG] && ctrl_q[CTRL_ALM_IE];

  // ---------------- watchdog ----------------
  rtc_wdog #(.W(DATA_W)) i_wdog (
    .clk(clk), .rst_n(rst_n), .load(wr_wdg), .load_val(bus_wdata),
    .en(ctrl_q[CTRL_WD_EN]), .tick(ms_tick),
    .count_q(wd_count), .rst_req_q(wdog_rst_req)
  );

  // ---------------- read path ----------------
  assign stat_val = {1'b1, 2'b00, strap_xtal32000, strap_xtal32768, 3'b000,
                     stale_q, 16'h0000};

  always_comb begin
    case (region)
      RGN_CTRL: bus_rdata = ctrl_q;
      RGN_STAT: bus_rdata = stat_val;
      RGN_SEC:  bus_rdata = live_sec_q;
      RGN_ALM:  bus_rdata = live_alm_q;
      RGN_WDG:  bus_rdata = wd_count;
      RGN_P0:   bus_rdata = live_p0_q;
      RGN_P1:   bus_rdata = live_p1_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_keeper_chk.sv
module rtc_keeper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        upd_strobe,
  input logic        sec_tick,
  input logic [7:0]  stale,
  input logic [31:0] ctrl,
  input logic [31:0] live_sec,
  input logic        sec_commit,
  input logic [31:0] wd_count,
  input logic        wdog_rst_req
);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && !(bus_wr && bus_addr == 8'h08 && bus_wdata[2])) |=> ctrl[2]);

  // R4
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && !bus_wr && stale != 8'h00)
      |=> $countones(stale) == $countones($past(stale)) - 1);

  // R3
  sec_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h30) |=> stale[7]);

  // R6
  sec_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !sec_commit) |=> live_sec == $past(live_sec) + 32'd1);

  // R9
  wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[4] && !(bus_wr && bus_addr == 8'h50)) |=> $stable(wd_count));

  // R10
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> !wdog_rst_req);

  // R10
  rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> wd_count == 32'd0);
endmodule

bind rtc_keeper rtc_keeper_chk i_rtc_keeper_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .upd_strobe(upd_strobe), .sec_tick(sec_tick),
  .stale(stale_q), .ctrl(ctrl_q), .live_sec(live_sec_q),
  .sec_commit(sec_commit), .wd_count(wd_count), .wdog_rst_req(wdog_rst_req)
);

// File: tb/test_rtc_keeper.sv
module test_rtc_keeper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sec_tick = 1'b0, ms_tick = 1'b0, upd_strobe = 1'b0;
  logic        strap_xtal32000 = 1'b1, strap_xtal32768 = 1'b0;
  logic        alarm_irq, wdog_rst_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_keeper i_rtc_keeper (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .ms_tick(ms_tick), .upd_strobe(upd_strobe),
    .strap_xtal32000(strap_xtal32000), .strap_xtal32768(strap_xtal32768),
    .alarm_irq(alarm_irq), .wdog_rst_req(wdog_rst_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_strobe();
    @(negedge clk); upd_strobe = 1'b1;
    @(negedge clk); upd_strobe = 1'b0;
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic pulse_ms();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h30, v); chk("R1 seconds", v, 32'h0);
    rd(8'h60, v); chk("R1 pers0", v, 32'h0);
    rd(8'h50, v); chk("R1 watchdog", v, 32'h0);
    rd(8'h10, v); chk("R11 stat straps", v, 32'h9000_0000);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 base write", v, 32'h13);
    wr(8'h08, 32'h02);        rd(8'h00, v); chk("R2 clr alias", v, 32'h11);
    wr(8'h04, 32'h02);        rd(8'h00, v); chk("R2 set alias", v, 32'h13);
    wr(8'h00, 32'h0);         rd(8'h00, v); chk("R2 base clear", v, 32'h0);
  endtask

  task automatic t_stale();
    logic [31:0] v;
    wr(8'h30, 32'd100);
    wr(8'h40, 32'd103);
    rd(8'h10, v); chk("R3 stale sec+alarm", v, 32'h90C0_0000);
    rd(8'h30, v); chk("R3 seconds old value", v, 32'h0);
    wr(8'h64, 32'h06);
    rd(8'h10, v); chk("R3 stale pers0", v, 32'h90C1_0000);
    pulse_strobe();
    rd(8'h10, v); chk("R4 pers0 first", v, 32'h90C0_0000);
    rd(8'h60, v); chk("R4 pers0 committed", v, 32'h06);
    pulse_strobe();
    rd(8'h40, v); chk("R4 alarm second", v, 32'd103);
    rd(8'h30, v); chk("R4 seconds still old", v, 32'h0);
    pulse_strobe();
    rd(8'h30, v); chk("R4 seconds last", v, 32'd100);
    rd(8'h10, v); chk("R4 queue empty", v, 32'h9000_0000);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr(8'h04, 32'h01);
    pulse_sec();
    pulse_sec();
    rd(8'h30, v); chk("R6 two ticks", v, 32'd102);
    chk("R7 irq before match", {31'b0, alarm_irq}, 32'h0);
    pulse_sec();
    chk("R7 irq at match", {31'b0, alarm_irq}, 32'h1);
    rd(8'h00, v); chk("R7 flag set", v, 32'h05);
    rd(8'h60, v); chk("R8 wake flag", v, 32'h86);
    wr(8'h00, 32'h01); rd(8'h00, v); chk("R7 base keeps flag", v, 32'h05);
    wr(8'h04, 32'h00); rd(8'h00, v); chk("R7 set keeps flag", v, 32'h05);
    wr(8'h08, 32'h04); rd(8'h00, v); chk("R7 clr flag", v, 32'h01);
    chk("R7 irq cleared", {31'b0, alarm_irq}, 32'h0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    logic [7:0]  exp_stale;
    wr(8'h74, 32'h8000_0000);
    rd(8'h10, v); chk("R5 all stale", v, 32'h90FF_0000);
    exp_stale = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      pulse_strobe();
      exp_stale[i] = 1'b0;
      rd(8'h10, v); chk("R4 forced order", v, {8'h90, exp_stale, 16'h0});
    end
    rd(8'h30, v); chk("R5 seconds unchanged", v, 32'd103);
    rd(8'h60, v); chk("R5 pers0 unchanged", v, 32'h86);
    rd(8'h40, v); chk("R5 alarm unchanged", v, 32'd103);
    rd(8'h70, v); chk("R5 pers1 committed", v, 32'h8000_0000);
    wr(8'h78, 32'h8000_0000);
    rd(8'h10, v); chk("R5 no force on clear", v, 32'h9002_0000);
    pulse_strobe();
    rd(8'h70, v); chk("R3 pers1 cleared", v, 32'h0);
  endtask

  task automatic t_wdog();
    logic [31:0] v;
    wr(8'h50, 32'd3);
    pulse_ms(); pulse_ms();
    rd(8'h50, v); chk("R9 disabled hold", v, 32'd3);
    wr(8'h04, 32'h10);
    pulse_ms(); rd(8'h50, v); chk("R9 count 2", v, 32'd2);
    pulse_ms(); rd(8'h50, v); chk("R9 count 1", v, 32'd1);
    chk("R10 no early pulse", {31'b0, wdog_rst_req}, 32'h0);
    pulse_ms();
    #1 chk("R10 pulse high", {31'b0, wdog_rst_req}, 32'h1);
    rd(8'h50, v); chk("R9 reached zero", v, 32'd0);
    @(negedge clk);
    #1 chk("R10 pulse one cycle", {31'b0, wdog_rst_req}, 32'h0);
    pulse_ms();
    #1 chk("R10 no pulse at zero", {31'b0, wdog_rst_req}, 32'h0);
    rd(8'h50, v); chk("R9 holds zero", v, 32'd0);
    wr(8'h50, 32'd0);
    pulse_ms();
    #1 chk("R10 zero write disables", {31'b0, wdog_rst_req}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_stale();
    t_alarm();
    t_force();
    t_wdog();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule